// File: doc/BRIEF.md
# Pseudo-Random Translation-Buffer Victim Index Generator

This block supplies a replacement slot number for a translation buffer whenever a miss handler asks for one. A pinned-entry boundary input (`wired_i`) marks how many of the lowest slots are reserved and must never be evicted. The returned slot always lies between that boundary and the highest slot.

The block keeps a 32-bit linear congruential state. Each accepted request steps the state as `state * 314159 + 1`, truncated to 32 bits. The block takes the top 16 bits of the stepped state and reduces them modulo the count of unreserved slots. It then adds the boundary to form the slot number. A bit-serial restoring reducer performs the reduction, one dividend bit per clock.

The state moves only on accepted requests. The sequence of slot numbers therefore depends only on how many requests have been accepted since reset. A request made while a reduction is running is dropped.

Top module: `tlb_victim_gen`

## Requirements
- R1: After reset `valid_o` is 0 and `idx_o` is 0, and the state is 0. With `wired_i` = 0, the first result is therefore 0.
- R2: Each accepted request replaces the 32-bit state S with (S * 314159 + 1) mod 2^32 before the slot is computed.
- R3: When `wired_i` < ENTRIES, the result is (S[31:16] mod (ENTRIES - `wired_i`)) + `wired_i`, where S is the stepped state and S[31:16] is its top 16 bits.
- R4: Every result with `wired_i` < ENTRIES lies in the range [`wired_i`, ENTRIES-1].
- R5: When `wired_i` >= ENTRIES, the result is ENTRIES-1, and no division by zero takes place.
- R6: `valid_o` rises at the 16th rising clock edge after the edge that accepts a request. It then stays high with `idx_o` unchanged until the next request is accepted.
- R7: A request is accepted only when no reduction is running. A request made while a reduction runs is ignored: the state does not step and no extra result appears.
- R8: On the edge that accepts a request, `valid_o` falls. It stays low until that request's result is ready.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| req_i | input | 1 | Request strobe for a new victim slot |
| wired_i | input | $clog2(ENTRIES)+1 | Count of reserved low slots, sampled when a request is accepted |
| idx_o | output | $clog2(ENTRIES) | Selected victim slot |
| valid_o | output | 1 | `idx_o` holds the result of the last accepted request |

## Verification
Each result is due exactly 16 clock edges after the edge that accepted its request. The monitor records the cycle of acceptance and checks that the rising edge of `valid_o` falls precisely 16 cycles later. It compares the slot against a queued value that a software copy of the congruential sequence computed. A probe one half-cycle after acceptance checks that `valid_o` has dropped, and a later probe checks that a request made during a running reduction leaves `valid_o` low and does not shift the queued sequence. A hold probe several cycles after a result checks that the slot and `valid_o` stay stable.

// File: rtl/tlbrnd_pkg.sv
package tlbrnd_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } gen_st_e;
endpackage

// File: rtl/tlbrnd_lcg.sv
module tlbrnd_lcg #(
  parameter int SEED_W = 32,
  parameter int MULT   = 314159,
  parameter int INC    = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  output logic [SEED_W-1:0] seed_nxt_o
);
  logic [SEED_W-1:0] seed_q, seed_d, stepped;

  assign stepped    = seed_q * SEED_W'(MULT) + SEED_W'(INC);
  assign seed_nxt_o = stepped;

  always_comb begin
    seed_d = seed_q;
    if (step_i) seed_d = stepped;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seed_q <= '0;
    else         seed_q <= seed_d;
  end

  AST_SEED_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(seed_q)); // R7
endmodule

// File: rtl/tlbrnd_mod_reducer.sv
module tlbrnd_mod_reducer #(
  parameter int NUM_W = 16,
  parameter int DEN_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output logic             busy_o,
  output logic             last_o,
  output logic [DEN_W-1:0] rem_nxt_o
);
  localparam int CNT_W = (NUM_W > 1) ? $clog2(NUM_W) : 1;

  logic [NUM_W-1:0] num_q, num_d;
  logic [DEN_W-1:0] den_q, den_d, rem_q, rem_d, rem_step;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             busy_q, busy_d;
  logic [DEN_W:0]   trial, diff;
  logic             fits;

  assign trial    = {rem_q, num_q[NUM_W-1]};
  assign diff     = trial - {1'b0, den_q};
  assign fits     = trial >= {1'b0, den_q};
  assign rem_step = fits ? diff[DEN_W-1:0] : trial[DEN_W-1:0];

  assign busy_o    = busy_q;
  assign last_o    = busy_q && (cnt_q == CNT_W'(NUM_W-1));
  assign rem_nxt_o = rem_step;

  always_comb begin
    num_d  = num_q;
    den_d  = den_q;
    rem_d  = rem_q;
    cnt_d  = cnt_q;
    busy_d = busy_q;
    if (start_i) begin
      num_d  = num_i;
      den_d  = den_i;
      rem_d  = '0;
      cnt_d  = '0;
      busy_d = 1'b1;
    end else if (busy_q) begin
      num_d = num_q << 1;
      rem_d = rem_step;
      cnt_d = cnt_q + CNT_W'(1);
      if (last_o) busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      num_q  <= '0;
      den_q  <= '0;
      rem_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      num_q  <= num_d;
      den_q  <= den_d;
      rem_q  <= rem_d;
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
    end
  end

  AST_REM_BELOW_DEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (rem_q < den_q)); // R3
  AST_NO_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_q); // R7
endmodule

// File: rtl/tlb_victim_gen.sv
module tlb_victim_gen #(
  parameter int ENTRIES = 16,
  parameter int SEED_W  = 32,
  parameter int MULT    = 314159
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         req_i,
  input  logic [$clog2(ENTRIES):0]     wired_i,
  output logic [$clog2(ENTRIES)-1:0]   idx_o,
  output logic                         valid_o
);
  import tlbrnd_pkg::*;

  localparam int IDX_W   = $clog2(ENTRIES);
  localparam int WIRED_W = IDX_W + 1;
  localparam int DEN_W   = IDX_W + 1;
  localparam int HALF_W  = SEED_W / 2;

  gen_st_e          st_q, st_d;
  logic             valid_q, valid_d, sat_q, sat_d;
  logic [IDX_W-1:0] idx_q, idx_d, wired_q, wired_d;
  logic             accept, sat_w, last_w, busy_w;
  logic [DEN_W-1:0] den_w, rem_w;
  logic [SEED_W-1:0] seed_nxt;

  assign accept = req_i && (st_q == ST_IDLE);
  assign sat_w  = wired_i >= WIRED_W'(ENTRIES);
  assign den_w  = sat_w ? DEN_W'(1) : (DEN_W'(ENTRIES) - DEN_W'(wired_i));

  tlbrnd_lcg #(.SEED_W(SEED_W), .MULT(MULT), .INC(1)) u_lcg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .step_i     (accept),
    .seed_nxt_o (seed_nxt)
  );

  tlbrnd_mod_reducer #(.NUM_W(SEED_W - HALF_W), .DEN_W(DEN_W)) u_red (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (accept),
    .num_i     (seed_nxt[SEED_W-1:HALF_W]),
    .den_i     (den_w),
    .busy_o    (busy_w),
    .last_o    (last_w),
    .rem_nxt_o (rem_w)
  );

  always_comb begin
    st_d    = st_q;
    valid_d = valid_q;
    idx_d   = idx_q;
    wired_d = wired_q;
    sat_d   = sat_q;
    if (accept) begin
      st_d    = ST_BUSY;
      valid_d = 1'b0;
      wired_d = wired_i[IDX_W-1:0];
      sat_d   = sat_w;
    end else if (last_w) begin
      st_d    = ST_IDLE;
      valid_d = 1'b1;
      idx_d   = sat_q ? IDX_W'(ENTRIES-1) : (rem_w[IDX_W-1:0] + wired_q);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      valid_q <= 1'b0;
      idx_q   <= '0;
      wired_q <= '0;
      sat_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      valid_q <= valid_d;
      idx_q   <= idx_d;
      wired_q <= wired_d;
      sat_q   <= sat_d;
    end
  end

  assign idx_o   = idx_q;
  assign valid_o = valid_q;

  AST_IDX_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !sat_q) |-> (idx_o >= wired_q)); // R4
  AST_SAT_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && sat_q) |-> (idx_o == IDX_W'(ENTRIES-1))); // R5
  AST_VALID_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !req_i) |=> (valid_o && $stable(idx_o))); // R6
  AST_ACCEPT_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && st_q == ST_IDLE) |=> !valid_o); // R8
  AST_BUSY_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_BUSY) |-> busy_w); // R7
endmodule

// File: tb/sim_tlb_victim_gen.sv
module sim_tlb_victim_gen;
  localparam int CLK_PERIOD = 10;
  localparam int ENTRIES    = 16;
  localparam int LAT        = 16;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       req;
  logic [4:0] wired;
  logic [3:0] idx;
  logic       valid;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int req_cyc = 0;
  bit pending = 0;
  bit prev_valid = 0;
  logic [31:0] mseed = '0;
  int    exp_q[$];
  string tag_q[$];
  int    wlo_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  tlb_victim_gen u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .wired_i(wired),
    .idx_o(idx), .valid_o(valid)
  );

  function automatic int model_idx(input logic [31:0] s, input int w);
    if (w >= ENTRIES) return ENTRIES - 1;
    return (int'(s[31:16]) % (ENTRIES - w)) + w;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Monitor: pop the expected slot when valid rises
  always @(negedge clk) begin
    if (rst_n) begin
      if (valid && !prev_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R7 unexpected result", int'(idx), -1);
        end else begin
          int e, lo;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          lo = wlo_q.pop_front();
          check(int'(idx) == e, t, int'(idx), e);
          check(int'(idx) >= lo && int'(idx) <= ENTRIES-1, "R4 range", int'(idx), lo);
          check(cyc - req_cyc == LAT, "R6 latency", cyc - req_cyc, LAT);
          pending = 0;
        end
      end
      prev_valid = valid;
    end
  end

  task automatic issue();
    while (pending) @(posedge clk);
    #1;
    mseed = mseed * 32'd314159 + 32'd1; // R2 state step
    exp_q.push_back(model_idx(mseed, int'(wired)));
    tag_q.push_back(int'(wired) >= ENTRIES ? "R5 saturated" : "R2 R3 index");
    wlo_q.push_back(int'(wired) >= ENTRIES ? ENTRIES-1 : int'(wired));
    pending = 1;
    req = 1'b1;
    @(posedge clk);
    #1;
    req = 1'b0;
    req_cyc = cyc;
    @(negedge clk);
    check(valid == 1'b0, "R8 valid drop", int'(valid), 0);
  endtask

  task automatic ignored_poke(input int k);
    repeat (k) @(posedge clk);
    #1 req = 1'b1;
    @(posedge clk);
    #1 req = 1'b0;
    @(negedge clk);
    check(valid == 1'b0, "R7 busy request", int'(valid), 0);
  endtask

  task automatic run_set(input int w, input int n);
    while (pending) @(posedge clk);
    #1 wired = 5'(w);
    for (int i = 0; i < n; i++) issue();
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    req   = 1'b0;
    wired = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(valid == 1'b0, "R1 reset valid", int'(valid), 0);
    check(idx == 4'd0, "R1 reset index", int'(idx), 0);

    // First result from a zero state with no reserved slots
    issue();
    while (pending) @(posedge clk);
    @(negedge clk);
    check(idx == 4'd0, "R1 first result", int'(idx), 0);

    // Hold after completion
    repeat (4) @(negedge clk);
    check(valid == 1'b1 && idx == 4'd0, "R6 hold", int'(idx), 0);

    run_set(0, 6);
    run_set(3, 6);
    run_set(15, 3);
    run_set(16, 3);
    run_set(31, 2);

    // Requests during a running reduction are dropped
    run_set(8, 1);
    ignored_poke(5);
    issue();
    ignored_poke(2);
    issue();
    ignored_poke(12);

    run_set(5, 5);
    run_set(0, 4);
    while (pending) @(posedge clk);
    @(negedge clk);
    begin
      int last;
      last = int'(idx);
      repeat (6) @(negedge clk);
      check(valid == 1'b1 && int'(idx) == last, "R6 final hold", int'(idx), last);
    end
    finish_run();
  end
endmodule